// File: doc/BRIEF.md
# Oscillator Timing, Reset Qualification and Power-Mode Controller

This block turns the raw oscillator of a small 8-bit microcontroller into the timing that the rest of the core runs on. A toggle stage halves the oscillator. A phase counter then divides each machine cycle of twelve oscillator periods into six two-period phases. The block emits a one-period machine-cycle strobe and one strobe per phase. All logic is clocked by the oscillator itself, and the downstream logic uses the strobes and enables as clock qualifiers.

The external reset pin is handled on two paths. The port-preset output follows the pin at once and without any clock, so the I/O pins go high immediately. The synchronous core reset is raised only once the synchronised pin has stayed high for two whole machine cycles. A short glitch therefore leaves the core and the machine-cycle phase untouched.

Two power-saving modes are entered by writing a mode byte. Idle drops only the CPU enable and ends on a wake-up request at a machine-cycle boundary. Power-down drops both enables, freezes all timing, and ends only through a qualified reset. A power-on reset input initialises the controller's own state.

Top module: `clkRstPwrCtl`

## Requirements
- R1: While power-on reset is active and in the cycles after it is released, sysRst is high, cpuClkEn and periphClkEn are high, and portPreset is high.
- R2: While timing runs, mcStrobe is high for exactly one oscillator cycle out of every 12 running cycles. The first strobe comes 11 cycles after power-on reset is released.
- R3: phaseOneHot carries one bit per two-oscillator phase of the machine cycle. Bit i is high during running cycles 2i and 2i+1 of the cycle, so at most one bit is high at a time, and bit 5 coincides with mcStrobe.
- R4: rstPin passes through a 2-stage synchroniser. sysRst rises at the first machine-cycle boundary where the synchronised pin has been high for at least 24 oscillator cycles. It falls at the first boundary where the synchronised pin is low.
- R5: portPreset is high whenever rstPin is high, in the same cycle and without waiting for qualification, and also whenever sysRst is high.
- R6: A reset pulse too short to qualify leaves sysRst low and does not shift the position of mcStrobe or phaseOneHot.
- R7: Writing the mode byte with bit 0 set and bit 1 clear enters idle: cpuClkEn goes low in the next cycle and periphClkEn stays high.
- R8: Writing the mode byte with bit 1 set enters power-down, and this takes priority over bit 0. Both enables go low, and mcStrobe and phaseOneHot stay low while the synchronised pin is low.
- R9: In idle, a wakeReq pulse restores cpuClkEn at the next machine-cycle boundary, counting a boundary in the same cycle as the request. In power-down, wakeReq has no effect.
- R10: Power-down ends only through a qualified reset. While the synchronised pin is high, the timing runs again so that qualification can complete, and mode-byte writes during power-down are ignored.
- R11: While sysRst is high, mode-byte writes are ignored. A qualified reset clears idle, power-down and any pending wake-up, even one that arrives in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| oscClk | input | 1 | Raw oscillator clock |
| pwrOnRstN | input | 1 | Active-low power-on reset of the controller itself |
| rstPin | input | 1 | External reset pin, asynchronous, active high |
| modeWrite | input | 1 | Write strobe for the mode byte |
| modeData | input | 8 | Mode byte: bit 0 idle, bit 1 power-down, other bits unused |
| wakeReq | input | 1 | Enabled interrupt request used to leave idle |
| mcStrobe | output | 1 | One-cycle machine-cycle boundary strobe |
| phaseOneHot | output | 6 | Phase strobes, one bit per two-period phase |
| cpuClkEn | output | 1 | Clock enable for the CPU |
| periphClkEn | output | 1 | Clock enable for RAM, timers, serial and interrupt logic |
| sysRst | output | 1 | Qualified synchronous core reset |
| portPreset | output | 1 | Asynchronous preset of all port outputs |

## Verification
Two functions meet in the same cycle in two cases. In the first, a wake-up is pending or arrives while idle, and the reset boundary that qualifies the pin lands in the same cycle. In the second, a mode-byte write is issued while the core reset is still asserted. The bench provokes the first by holding wakeReq high during a long reset pulse taken from idle, and the second by writing the idle code right after sysRst rises. A cycle model built from the requirements decides the result each cycle: the reset must win and the write must leave no trace on cpuClkEn. A sweep of reset pulse lengths from 1 to 30 oscillator cycles against all twelve starting phases checks the qualification threshold and the phase stability together.

// File: rtl/clkRstPwrPkg.sv
`timescale 1ns/1ps
package clkRstPwrPkg;
  // control -> datapath
  typedef struct packed {
    logic run;          // timing advances this cycle
  } ctlCmd_t;

  // datapath -> control
  typedef struct packed {
    logic mcBoundary;   // last oscillator cycle of a machine cycle
    logic pinSync;      // synchronised reset pin
    logic qualFull;     // pin held long enough to qualify
  } dpStat_t;
endpackage

// File: rtl/clkRstTiming.sv
`timescale 1ns/1ps
module clkRstTiming
  import clkRstPwrPkg::*;
#(
  parameter int OSC_PER_MC  = 12,
  parameter int QUAL_MC     = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       oscClk,
  input  logic                       pwrOnRstN,
  input  logic                       rstPin,
  input  ctlCmd_t                    cmd,
  output dpStat_t                    stat,
  output logic [OSC_PER_MC/2-1:0]    phaseOneHot
);
  localparam int PHASES     = OSC_PER_MC / 2;
  localparam int PH_W       = (PHASES > 1) ? $clog2(PHASES) : 1;
  localparam int QUAL_LIMIT = QUAL_MC * OSC_PER_MC;
  localparam int Q_W        = $clog2(QUAL_LIMIT + 1);

  logic                   halfTick;
  logic [PH_W-1:0]        phaseCnt;
  logic [SYNC_STAGES-1:0] syncQ;
  logic [Q_W-1:0]         qualCnt;

  // divide-by-two stage and phase counter; the pin never resets them
  always_ff @(posedge oscClk or negedge pwrOnRstN) begin
    if (!pwrOnRstN) begin
      halfTick <= 1'b0;
      phaseCnt <= '0;
    end else if (cmd.run) begin
      halfTick <= ~halfTick;
      if (halfTick)
        phaseCnt <= (phaseCnt == PH_W'(PHASES - 1)) ? '0 : phaseCnt + 1'b1;
    end
  end

  always_ff @(posedge oscClk or negedge pwrOnRstN) begin
    if (!pwrOnRstN) syncQ <= '0;
    else            syncQ <= {syncQ[SYNC_STAGES-2:0], rstPin};
  end

  always_ff @(posedge oscClk or negedge pwrOnRstN) begin
    if (!pwrOnRstN)                     qualCnt <= '0;
    else if (!syncQ[SYNC_STAGES-1])     qualCnt <= '0;
    else if (qualCnt != Q_W'(QUAL_LIMIT)) qualCnt <= qualCnt + 1'b1;
  end

  assign stat.pinSync    = syncQ[SYNC_STAGES-1];
  assign stat.qualFull   = (qualCnt == Q_W'(QUAL_LIMIT));
  assign stat.mcBoundary = cmd.run && halfTick && (phaseCnt == PH_W'(PHASES - 1));

  for (genvar i = 0; i < PHASES; i++) begin : g_phase
    assign phaseOneHot[i] = cmd.run && (phaseCnt == PH_W'(i));
  end

  // R8: a stopped timing chain keeps its phase
  assert_freeze_R8: assert property (@(posedge oscClk) disable iff (!pwrOnRstN)
    !cmd.run |=> ($stable(phaseCnt) && $stable(halfTick)));
  // R2: boundary strobe never lasts two cycles
  assert_strobe_single_R2: assert property (@(posedge oscClk) disable iff (!pwrOnRstN)
    stat.mcBoundary |=> !stat.mcBoundary);
  // R3: at most one phase strobe
  assert_phase_onehot_R3: assert property (@(posedge oscClk) disable iff (!pwrOnRstN)
    $onehot0(phaseOneHot));
endmodule

// File: rtl/clkRstPwrFsm.sv
`timescale 1ns/1ps
module clkRstPwrFsm
  import clkRstPwrPkg::*;
(
  input  logic       oscClk,
  input  logic       pwrOnRstN,
  input  logic       modeWrite,
  input  logic [7:0] modeData,
  input  logic       wakeReq,
  input  dpStat_t    stat,
  output ctlCmd_t    cmd,
  output logic       sysRst,
  output logic       cpuClkEn,
  output logic       periphClkEn
);
  logic idleMode, pdMode, wakePend;
  logic qualHit;

  assign qualHit = stat.mcBoundary && stat.qualFull;
  assign cmd.run = !pdMode || stat.pinSync;

  always_ff @(posedge oscClk or negedge pwrOnRstN) begin
    if (!pwrOnRstN) begin
      sysRst <= 1'b1;
    end else if (stat.mcBoundary) begin
      if (stat.qualFull)      sysRst <= 1'b1;
      else if (!stat.pinSync) sysRst <= 1'b0;
    end
  end

  always_ff @(posedge oscClk or negedge pwrOnRstN) begin
    if (!pwrOnRstN) begin
      idleMode <= 1'b0;
      pdMode   <= 1'b0;
      wakePend <= 1'b0;
    end else if (sysRst || qualHit) begin
      idleMode <= 1'b0;
      pdMode   <= 1'b0;
      wakePend <= 1'b0;
    end else if (modeWrite && !pdMode) begin
      pdMode   <= modeData[1];
      idleMode <= modeData[0] && !modeData[1];
      wakePend <= 1'b0;
    end else if (idleMode) begin
      if (stat.mcBoundary && (wakePend || wakeReq)) begin
        idleMode <= 1'b0;
        wakePend <= 1'b0;
      end else if (wakeReq) begin
        wakePend <= 1'b1;
      end
    end
  end

  assign cpuClkEn    = !idleMode && !pdMode;
  assign periphClkEn = !pdMode;

  // R4: core reset only rises on a qualifying boundary
  assert_rst_rise_R4: assert property (@(posedge oscClk) disable iff (!pwrOnRstN)
    $rose(sysRst) |-> $past(qualHit));
  // R10: power-down ends only by reset
  assert_pd_exit_R10: assert property (@(posedge oscClk) disable iff (!pwrOnRstN)
    $fell(pdMode) |-> $past(sysRst || qualHit));
  // R9: idle ends at a boundary, a write or a reset
  assert_wake_boundary_R9: assert property (@(posedge oscClk) disable iff (!pwrOnRstN)
    $fell(idleMode) |-> $past(stat.mcBoundary || modeWrite || sysRst));
endmodule

// File: rtl/clkRstPwrCtl.sv
`timescale 1ns/1ps
module clkRstPwrCtl
  import clkRstPwrPkg::*;
#(
  parameter int OSC_PER_MC  = 12,
  parameter int QUAL_MC     = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                    oscClk,
  input  logic                    pwrOnRstN,
  input  logic                    rstPin,
  input  logic                    modeWrite,
  input  logic [7:0]              modeData,
  input  logic                    wakeReq,
  output logic                    mcStrobe,
  output logic [OSC_PER_MC/2-1:0] phaseOneHot,
  output logic                    cpuClkEn,
  output logic                    periphClkEn,
  output logic                    sysRst,
  output logic                    portPreset
);
  ctlCmd_t cmd;
  dpStat_t stat;

  clkRstTiming #(
    .OSC_PER_MC(OSC_PER_MC), .QUAL_MC(QUAL_MC), .SYNC_STAGES(SYNC_STAGES)
  ) i_timing (
    .oscClk(oscClk), .pwrOnRstN(pwrOnRstN), .rstPin(rstPin),
    .cmd(cmd), .stat(stat), .phaseOneHot(phaseOneHot)
  );

  clkRstPwrFsm i_fsm (
    .oscClk(oscClk), .pwrOnRstN(pwrOnRstN), .modeWrite(modeWrite),
    .modeData(modeData), .wakeReq(wakeReq), .stat(stat), .cmd(cmd),
    .sysRst(sysRst), .cpuClkEn(cpuClkEn), .periphClkEn(periphClkEn)
  );

  assign mcStrobe   = stat.mcBoundary;
  assign portPreset = rstPin | sysRst;

  // R8: no enable survives power-down
  assert_pd_enables_R8: assert property (@(posedge oscClk) disable iff (!pwrOnRstN)
    !periphClkEn |-> !cpuClkEn);
endmodule

// File: tb/test_clkRstPwrCtl.sv
`timescale 1ns/1ps
module test_clkRstPwrCtl;
  logic oscClk = 1'b0;
  logic pwrOnRstN = 1'b0;
  logic rstPin = 1'b0;
  logic modeWrite = 1'b0;
  logic [7:0] modeData = 8'h00;
  logic wakeReq = 1'b0;
  logic mcStrobe, cpuClkEn, periphClkEn, sysRst, portPreset;
  logic [5:0] phaseOneHot;

  int testCount = 0;
  int failCount = 0;
  bit done = 0;
  bit checking = 0;

  always #2.5 oscClk = ~oscClk;

  clkRstPwrCtl i_clkRstPwrCtl (
    .oscClk(oscClk), .pwrOnRstN(pwrOnRstN), .rstPin(rstPin),
    .modeWrite(modeWrite), .modeData(modeData), .wakeReq(wakeReq),
    .mcStrobe(mcStrobe), .phaseOneHot(phaseOneHot), .cpuClkEn(cpuClkEn),
    .periphClkEn(periphClkEn), .sysRst(sysRst), .portPreset(portPreset)
  );

  // cycle model built from the requirements
  int mk = 0, hc = 0;
  bit s1 = 0, s2 = 0, mRst = 1, mIdle = 0, mPd = 0, mPend = 0;

  always @(posedge oscClk) begin
    bit run, bnd, full, nRst;
    if (!pwrOnRstN) begin
      mk = 0; hc = 0; s1 = 0; s2 = 0; mRst = 1; mIdle = 0; mPd = 0; mPend = 0;
    end else begin
      run  = !mPd || s2;
      bnd  = run && (mk == 11);
      full = (hc == 24);
      nRst = mRst;
      if (bnd) begin
        if (full) nRst = 1;
        else if (!s2) nRst = 0;
      end
      if (mRst || (bnd && full)) begin
        mIdle = 0; mPd = 0; mPend = 0;
      end else if (modeWrite && !mPd) begin
        mPd = modeData[1]; mIdle = modeData[0] && !modeData[1]; mPend = 0;
      end else if (mIdle) begin
        if (bnd && (mPend || wakeReq)) begin mIdle = 0; mPend = 0; end
        else if (wakeReq) mPend = 1;
      end
      hc = !s2 ? 0 : ((hc < 24) ? hc + 1 : hc);
      if (run) mk = (mk + 1) % 12;
      s2 = s1; s1 = rstPin;
      mRst = nRst;
    end
  end

  task automatic check(input logic got, input logic exp, input string tag);
    testCount++;
    if (got !== exp) begin
      failCount++;
      $display("FAIL %s: got %0b expected %0b at %0t", tag, got, exp, $time);
    end
  endtask

  always @(negedge oscClk) begin
    bit run;
    logic [5:0] expPh;
    if (checking && !done) begin
      run = !mPd || s2;
      expPh = run ? (6'b1 << (mk / 2)) : 6'b0;
      check(mcStrobe, run && (mk == 11), "R2 R6 R8 mcStrobe");
      testCount++;
      if (phaseOneHot !== expPh) begin
        failCount++;
        $display("FAIL R3 R6 phaseOneHot: got %b expected %b at %0t", phaseOneHot, expPh, $time);
      end
      check(sysRst, mRst, "R4 R6 R11 sysRst");
      check(portPreset, rstPin || mRst, "R5 portPreset");
      check(cpuClkEn, !mIdle && !mPd, "R7 R9 R11 cpuClkEn");
      check(periphClkEn, !mPd, "R8 R10 periphClkEn");
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge oscClk);
  endtask

  task automatic waitPhase(input int off);
    while (mk != off) @(negedge oscClk);
  endtask

  task automatic writeMode(input logic [7:0] v);
    modeWrite = 1'b1; modeData = v;
    cyc(1);
    modeWrite = 1'b0; modeData = 8'h00;
  endtask

  initial begin
    cyc(3);
    // R1: state during power-on reset
    check(sysRst, 1'b1, "R1 sysRst in reset");
    check(portPreset, 1'b1, "R1 portPreset in reset");
    check(cpuClkEn, 1'b1, "R1 cpuClkEn in reset");
    check(periphClkEn, 1'b1, "R1 periphClkEn in reset");
    pwrOnRstN = 1'b1;
    checking = 1;
    cyc(1);
    check(sysRst, 1'b1, "R1 sysRst after release");
    cyc(30);
    // R4 R6: pulse lengths against every start phase
    for (int len = 1; len <= 30; len++) begin
      for (int off = 0; off < 12; off++) begin
        waitPhase(off);
        rstPin = 1'b1;
        cyc(len);
        rstPin = 1'b0;
        cyc(40);
      end
    end
    // R7 R9: idle and wake at every phase
    for (int off = 0; off < 12; off++) begin
      writeMode(8'h01);
      cyc(5);
      waitPhase(off);
      wakeReq = 1'b1;
      cyc(1);
      wakeReq = 1'b0;
      cyc(20);
    end
    // R8 R9 R10: power-down with both bits, ignored wake and write
    writeMode(8'h03);
    cyc(30);
    wakeReq = 1'b1; cyc(2); wakeReq = 1'b0;
    writeMode(8'h00);
    cyc(20);
    rstPin = 1'b1; cyc(40); rstPin = 1'b0; cyc(40);
    // R10: short pulse in power-down must not exit
    writeMode(8'h02);
    cyc(10);
    rstPin = 1'b1; cyc(8); rstPin = 1'b0; cyc(30);
    rstPin = 1'b1; cyc(45); rstPin = 1'b0; cyc(40);
    // R11: wake held during qualifying reset from idle, write during sysRst
    writeMode(8'h01);
    cyc(3);
    wakeReq = 1'b1; rstPin = 1'b1;
    while (!sysRst) @(negedge oscClk);
    wakeReq = 1'b0;
    writeMode(8'h01);
    cyc(5);
    rstPin = 1'b0;
    cyc(40);
    check(cpuClkEn, 1'b1, "R11 write during reset ignored");
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    #750000;
    if (!done) begin
      done = 1;
      failCount++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end
endmodule